// File: doc/BRIEF.md
# Multiplexed Address/Data Parallel Port

This block is the host side of a narrow external parallel port. A single 16-bit bus of shared pins carries the address first and then the data. An address strobe (`ale`) marks the first phase, and external logic latches the address from the pins while it is high. In the second phase, `ale` is low and a read or write strobe is active. The data half of the pins carries the transfer payload in that phase. A byte-wide mode reaches a 24-bit address space, and a word-wide mode reaches a 16-bit address space.

In byte mode, the address phase places address bits 23..8 on the pins. The data phase places address bits 7..0 on the upper pin half next to the data byte on the lower half. In word mode, the address phase carries address bits 15..0 and the data phase carries the whole data word.

A disable input hands the pins to a general-purpose flag function. Each flag then has its own output-enable and output-value bit, and the two pin halves are numbered in crossed order. The core side uses a single-cycle request and a single-cycle acknowledge. The core sets the address phase length and the data phase length in core clock cycles.

Top module: `mux_ad_port`

## Requirements
- R1: After a request is accepted, `ale` is high from the next cycle for exactly max(`addr_cycles`,1) cycles, with all 16 pins driven.
- R2: In byte mode (`wide_mode`=0), the address phase drives `ad_out[15:8]` = A[23:16] and `ad_out[7:0]` = A[15:8].
- R3: In byte mode, the data phase drives `ad_out[15:8]` = A[7:0]. On a write it also drives `ad_out[7:0]` = D[7:0] with `ad_oe`=16'hFFFF. On a read, `ad_oe`=16'hFF00.
- R4: In word mode (`wide_mode`=1), the address phase drives A[15:0]. The data phase drives D[15:0] on a write (`ad_oe`=16'hFFFF) and releases all pins on a read (`ad_oe`=0).
- R5: The data phase follows the address phase directly and lasts max(`data_cycles`,1) cycles. `wr_strb` is high throughout a write data phase and `rd_strb` throughout a read data phase. Neither strobe is ever high together with `ale`.
- R6: A read samples `ad_in` on the last data-phase cycle. `rdata` then becomes `ad_in` in word mode, or {8'h00, `ad_in[7:0]`} in byte mode, and holds until the next read completes.
- R7: `ack` is a one-cycle pulse in the cycle after the last data-phase cycle. `busy` is high from the cycle after acceptance until that cycle.
- R8: `req` is ignored while `busy` is high or while `port_off` is high.
- R9: The mode, the phase lengths, the direction, the address and the write data are taken when the request is accepted. Changing these inputs during a transfer has no effect on it.
- R10: While idle with `port_off`=1, pin p is driven from flag p+8 for p<8 and from flag p-8 for p>=8, with `ad_oe[p]`=`flag_oe[f]` and `ad_out[p]`=`flag_val[f]`. `ale` and both strobes stay low.
- R11: `flag_sync[f]` equals the pin that feeds flag f, as above, delayed by two clock cycles.
- R12: While idle with `port_off`=0, `ad_oe`=0 and `ale`, `rd_strb`, `wr_strb`, `ack` are low. `busy`, `rdata` and `flag_sync` are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous active-low reset |
| port_off | input | 1 | 1 hands the pins to flag I/O |
| wide_mode | input | 1 | 1 = word mode, 0 = byte mode |
| addr_cycles | input | 4 | address phase length (0 treated as 1) |
| data_cycles | input | 4 | data phase length (0 treated as 1) |
| req | input | 1 | single-cycle transfer request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | transfer address |
| req_wdata | input | 16 | write data |
| busy | output | 1 | transfer in progress |
| ack | output | 1 | one-cycle completion pulse |
| rdata | output | 16 | last read data |
| ad_out | output | 16 | pin output values |
| ad_oe | output | 16 | pin output enables |
| ad_in | input | 16 | pin input values |
| ale | output | 1 | address latch enable |
| rd_strb | output | 1 | read strobe, active high |
| wr_strb | output | 1 | write strobe, active high |
| flag_oe | input | 16 | per-flag output enable |
| flag_val | input | 16 | per-flag output value |
| flag_sync | output | 16 | synchronized flag inputs |

## Verification
A transfer's completion acknowledge can fall in the same cycle as a new request. The bench raises `req` in the very cycle `ack` is seen, so the port must accept it and raise `ale` on the next cycle with no idle gap. The bench also changes `wide_mode`, the phase lengths and `port_off` while a transfer is running, so capture at acceptance and a late switch to flag mode meet in one cycle. A behavioural model predicts every pin, strobe, `ack` and `rdata` on every cycle, and any divergence is reported against the requirement it breaks.

// File: rtl/mp_pkg.sv
package mp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_t;
endpackage

// File: rtl/mp_phase_ctrl.sv
module mp_phase_ctrl
  import mp_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] alen,
  input  logic [CNT_W-1:0] dlen,
  output phase_t           phase,
  output logic             last_data,
  output logic             ack
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  phase_t           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] dlen_q, dlen_d;
  logic             ack_q, ack_d;
  logic             cnt_zero;

  function automatic logic [CNT_W-1:0] len_m1(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : (v - ONE);
  endfunction

  assign cnt_zero  = (cnt_q == '0);
  assign last_data = (phase_q == PH_DATA) && cnt_zero;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    dlen_d  = dlen_q;
    ack_d   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_ADDR;
          cnt_d   = len_m1(alen);
          dlen_d  = dlen;
        end
      end
      PH_ADDR: begin
        if (cnt_zero) begin
          phase_d = PH_DATA;
          cnt_d   = len_m1(dlen_q);
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      PH_DATA: begin
        if (cnt_zero) begin
          phase_d = PH_IDLE;
          ack_d   = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      dlen_q  <= '0;
      ack_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      dlen_q  <= dlen_d;
      ack_q   <= ack_d;
    end
  end

  assign phase = phase_q;
  assign ack   = ack_q;

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  assert_ack_after_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_data |=> (ack_q && phase_q == PH_IDLE));
  assert_start_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && phase_q == PH_IDLE) |=> (phase_q == PH_ADDR));
  assert_addr_to_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ADDR && cnt_zero) |=> (phase_q == PH_DATA));
  assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA && !cnt_zero) |=> (phase_q == PH_DATA));
endmodule

// File: rtl/mp_flag_io.sv
module mp_flag_io #(
  parameter int PIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pin_in,
  input  logic [PIN_W-1:0] flag_oe,
  input  logic [PIN_W-1:0] flag_val,
  output logic [PIN_W-1:0] pin_oe_map,
  output logic [PIN_W-1:0] pin_val_map,
  output logic [PIN_W-1:0] flag_sync
);
  localparam int HALF = PIN_W / 2;

  logic [PIN_W-1:0] flag_raw;
  logic [PIN_W-1:0] sync1_q, sync2_q;
  logic [1:0]       warm_q;

  for (genvar p = 0; p < PIN_W; p++) begin : g_pin
    localparam int FL = (p < HALF) ? (p + HALF) : (p - HALF);
    assign pin_oe_map[p]  = flag_oe[FL];
    assign pin_val_map[p] = flag_val[FL];
    assign flag_raw[FL]   = pin_in[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      warm_q  <= '0;
    end else begin
      sync1_q <= flag_raw;
      sync2_q <= sync1_q;
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
  end

  assign flag_sync = sync2_q;

  assert_flag_two_stage_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (sync2_q == $past({pin_in[HALF-1:0], pin_in[PIN_W-1:HALF]}, 2)));
endmodule

// File: rtl/mp_pin_mux.sv
module mp_pin_mux
  import mp_pkg::*;
#(
  parameter int PIN_W  = 16,
  parameter int ADDR_W = 24
) (
  input  phase_t            phase,
  input  logic              flag_mode,
  input  logic              wide,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PIN_W-1:0]  wdata,
  input  logic [PIN_W-1:0]  flag_oe_map,
  input  logic [PIN_W-1:0]  flag_val_map,
  output logic [PIN_W-1:0]  ad_out,
  output logic [PIN_W-1:0]  ad_oe,
  output logic              ale,
  output logic              rd_strb,
  output logic              wr_strb
);
  localparam int HALF = PIN_W / 2;
  localparam logic [PIN_W-1:0] UPPER = {{HALF{1'b1}}, {HALF{1'b0}}};

  always_comb begin
    ad_out  = '0;
    ad_oe   = '0;
    ale     = 1'b0;
    rd_strb = 1'b0;
    wr_strb = 1'b0;
    unique case (phase)
      PH_ADDR: begin
        ale   = 1'b1;
        ad_oe = '1;
        if (wide) ad_out = addr[PIN_W-1:0];
        else      ad_out = addr[ADDR_W-1:ADDR_W-PIN_W];
      end
      PH_DATA: begin
        rd_strb = !wr;
        wr_strb = wr;
        if (wide) begin
          ad_out = wr ? wdata : '0;
          ad_oe  = wr ? '1 : '0;
        end else begin
          ad_out = {addr[HALF-1:0], (wr ? wdata[HALF-1:0] : {HALF{1'b0}})};
          ad_oe  = wr ? '1 : UPPER;
        end
      end
      default: begin
        if (flag_mode) begin
          ad_out = flag_val_map;
          ad_oe  = flag_oe_map;
        end
      end
    endcase
  end
endmodule

// File: rtl/mux_ad_port.sv
module mux_ad_port
  import mp_pkg::*;
#(
  parameter int PIN_W  = 16,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_off,
  input  logic              wide_mode,
  input  logic [CNT_W-1:0]  addr_cycles,
  input  logic [CNT_W-1:0]  data_cycles,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PIN_W-1:0]  req_wdata,
  output logic              busy,
  output logic              ack,
  output logic [PIN_W-1:0]  rdata,
  output logic [PIN_W-1:0]  ad_out,
  output logic [PIN_W-1:0]  ad_oe,
  input  logic [PIN_W-1:0]  ad_in,
  output logic              ale,
  output logic              rd_strb,
  output logic              wr_strb,
  input  logic [PIN_W-1:0]  flag_oe,
  input  logic [PIN_W-1:0]  flag_val,
  output logic [PIN_W-1:0]  flag_sync
);
  localparam int HALF = PIN_W / 2;

  phase_t            phase;
  logic              last_data;
  logic              start;
  logic              wide_q, wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PIN_W-1:0]  wdata_q, rdata_q, rdata_d;
  logic              rd_load;
  logic [PIN_W-1:0]  oe_map, val_map;

  assign start   = req && !port_off && (phase == PH_IDLE);
  assign rd_load = last_data && !wr_q;
  assign rdata_d = wide_q ? ad_in : {{HALF{1'b0}}, ad_in[HALF-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q  <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      wide_q  <= wide_mode;
      wr_q    <= req_wr;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_load) rdata_q <= rdata_d;
  end

  mp_phase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .alen      (addr_cycles),
    .dlen      (data_cycles),
    .phase     (phase),
    .last_data (last_data),
    .ack       (ack)
  );

  mp_flag_io #(.PIN_W(PIN_W)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_in      (ad_in),
    .flag_oe     (flag_oe),
    .flag_val    (flag_val),
    .pin_oe_map  (oe_map),
    .pin_val_map (val_map),
    .flag_sync   (flag_sync)
  );

  mp_pin_mux #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_mux (
    .phase        (phase),
    .flag_mode    (port_off),
    .wide         (wide_q),
    .wr           (wr_q),
    .addr         (addr_q),
    .wdata        (wdata_q),
    .flag_oe_map  (oe_map),
    .flag_val_map (val_map),
    .ad_out       (ad_out),
    .ad_oe        (ad_oe),
    .ale          (ale),
    .rd_strb      (rd_strb),
    .wr_strb      (wr_strb)
  );

  assign busy  = (phase != PH_IDLE);
  assign rdata = rdata_q;

  assert_no_ale_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !(rd_strb || wr_strb));
  assert_ignore_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (port_off && !busy) |=> !busy);
  assert_capture_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(wide_q) && $stable(wr_q) && $stable(addr_q)));
  assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_load |=> $stable(rdata_q));
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !port_off) |-> (ad_oe == '0 && !ale && !rd_strb && !wr_strb));
endmodule

// File: tb/mux_ad_port_bench.sv
module mux_ad_port_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        port_off, wide_mode, req, req_wr;
  logic [3:0]  addr_cycles, data_cycles;
  logic [23:0] req_addr;
  logic [15:0] req_wdata, ad_in, flag_oe, flag_val;
  logic        busy, ack, ale, rd_strb, wr_strb;
  logic [15:0] rdata, ad_out, ad_oe, flag_sync;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mux_ad_port u_mux_ad_port (
    .clk(clk), .rst_n(rst_n), .port_off(port_off), .wide_mode(wide_mode),
    .addr_cycles(addr_cycles), .data_cycles(data_cycles), .req(req), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .ack(ack), .rdata(rdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .rd_strb(rd_strb),
    .wr_strb(wr_strb), .flag_oe(flag_oe), .flag_val(flag_val), .flag_sync(flag_sync)
  );

  // behavioural reference
  int          m_ph = 0;
  int          m_cnt = 0;
  int          m_dl = 0;
  logic [23:0] m_addr = '0;
  logic [15:0] m_wd = '0;
  logic [15:0] m_rdata = '0;
  logic [15:0] m_s1 = '0;
  logic [15:0] m_s2 = '0;
  bit          m_wr = 0;
  bit          m_wide = 0;
  bit          m_ack = 0;

  function automatic logic [15:0] swp(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_ack = 0; m_rdata = '0; m_s1 = '0; m_s2 = '0;
    end else begin
      m_s2 = m_s1;
      m_s1 = swp(ad_in);
      m_ack = 0;
      if (m_ph == 0) begin
        if (req && !port_off) begin
          m_ph = 1; m_addr = req_addr; m_wd = req_wdata; m_wr = req_wr; m_wide = wide_mode;
          m_cnt = (addr_cycles == 0) ? 1 : int'(addr_cycles);
          m_dl  = (data_cycles == 0) ? 1 : int'(data_cycles);
        end
      end else if (m_ph == 1) begin
        if (m_cnt == 1) begin m_ph = 2; m_cnt = m_dl; end
        else m_cnt--;
      end else begin
        if (m_cnt == 1) begin
          m_ph = 0; m_ack = 1;
          if (!m_wr) m_rdata = m_wide ? ad_in : {8'h00, ad_in[7:0]};
        end else m_cnt--;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [15:0] eo, ev;
      eo = '0; ev = '0;
      if (m_ph == 1) begin
        eo = 16'hFFFF; ev = m_wide ? m_addr[15:0] : m_addr[23:8];
      end else if (m_ph == 2) begin
        if (m_wide) begin eo = m_wr ? 16'hFFFF : 16'h0000; ev = m_wd; end
        else begin eo = m_wr ? 16'hFFFF : 16'hFF00; ev = {m_addr[7:0], m_wd[7:0]}; end
      end else if (port_off) begin
        eo = swp(flag_oe); ev = swp(flag_val);
      end
      chk("R1 ale", 32'(ale), 32'(m_ph == 1));
      chk(m_wide ? "R4 pin oe" : (m_ph == 0 ? (port_off ? "R10 pin oe" : "R12 pin oe") : "R3 pin oe"),
          32'(ad_oe), 32'(eo));
      chk(m_wide ? "R4 pin value" : (m_ph == 1 ? "R2 pin value" : "R3/R10 pin value"),
          32'(ad_out & eo), 32'(ev & eo));
      chk("R5 wr_strb", 32'(wr_strb), 32'(m_ph == 2 && m_wr));
      chk("R5 rd_strb", 32'(rd_strb), 32'(m_ph == 2 && !m_wr));
      chk("R7 ack", 32'(ack), 32'(m_ack));
      chk("R8 busy", 32'(busy), 32'(m_ph != 0));
      chk("R6 rdata", 32'(rdata), 32'(m_rdata));
      chk("R11 flag_sync", 32'(flag_sync), 32'(m_s2));
    end
  end

  // pin-side device: new random input every cycle
  always @(negedge clk) ad_in <= 16'($urandom);

  task automatic issue(input bit wr, input bit wide, input logic [23:0] a,
                       input logic [15:0] d, input logic [3:0] al, input logic [3:0] dl);
    @(negedge clk);
    req = 1; req_wr = wr; wide_mode = wide; req_addr = a; req_wdata = d;
    addr_cycles = al; data_cycles = dl;
    @(negedge clk);
    req = 0;
  endtask

  task automatic wait_ack();
    for (int i = 0; i < 100; i++) begin
      if (ack) return;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 0; port_off = 0; wide_mode = 0; req = 0; req_wr = 0;
    addr_cycles = 1; data_cycles = 1; req_addr = '0; req_wdata = '0;
    flag_oe = '0; flag_val = '0; ad_in = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset busy", 32'(busy), 0);
    chk("R12 reset ack", 32'(ack), 0);
    chk("R12 reset rdata", 32'(rdata), 0);
    chk("R12 reset oe", 32'(ad_oe), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R2 R3 byte-mode write and read
    issue(1, 0, 24'hA1B2C3, 16'h5E6F, 2, 3); wait_ack();
    issue(0, 0, 24'h123456, 16'h0000, 1, 2); wait_ack();
    // R4 word-mode write and read, zero lengths treated as one
    issue(1, 1, 24'h00BEEF, 16'hCAFE, 0, 0); wait_ack();
    issue(0, 1, 24'h00F00D, 16'h0000, 3, 4); wait_ack();
    // R8 request while busy, R9 inputs changed mid-transfer
    issue(1, 0, 24'h778899, 16'h00AB, 4, 5);
    wide_mode = 1; addr_cycles = 9; data_cycles = 9; req_addr = 24'hFFFFFF; req_wr = 0;
    req = 1; @(negedge clk); req = 0;
    wait_ack();
    // back-to-back: request in the ack cycle
    req = 1; req_wr = 0; wide_mode = 0; req_addr = 24'h3C3C3C; addr_cycles = 1; data_cycles = 1;
    @(negedge clk); req = 0;
    wait_ack();
    req = 1; req_wr = 1; wide_mode = 1; req_addr = 24'h00AAAA; req_wdata = 16'h1357;
    @(negedge clk); req = 0;
    wait_ack();
    @(negedge clk);
    // R10 flag mode, R8 request ignored while off
    port_off = 1; flag_oe = 16'h00FF; flag_val = 16'hA5C3;
    repeat (3) @(negedge clk);
    flag_oe = 16'hF0F0; flag_val = 16'h0F5A;
    req = 1; req_wr = 1; @(negedge clk); req = 0;
    repeat (4) @(negedge clk);
    // late switch to flag mode during a transfer
    port_off = 0;
    issue(0, 1, 24'h00C0DE, 16'h0, 2, 3);
    port_off = 1;
    wait_ack();
    repeat (3) @(negedge clk);
    port_off = 0;
    for (int k = 0; k < 20; k++) begin
      issue(k[0], k[1], 24'($urandom), 16'($urandom), 4'(k % 5), 4'(k % 7));
      wait_ack();
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule